// File: doc/BRIEF.md
# Windowed Watchdog Timer

This block is a watchdog timer that sits on a simple register bus. A 12-bit counter counts down by one on each pulse of `tick_i`, a single-cycle strobe at 256 Hz that comes from a slow-clock divider outside the block. Software must restart the counter before it reaches the end of its count.

A restart is only legal inside a window. The counter must have fallen to or below a programmable delta. A restart that comes too early is treated as a fault. So is a count that runs out.

Each fault sets a sticky status flag. Depending on the configuration, a fault also raises a level interrupt and pulses one or two reset outputs. The configuration register takes exactly one write after each system reset, and every later write is ignored. Once the block is running, software cannot switch it off.

Bus behaviour:
- An access is a single cycle and is always accepted. There is no back-pressure.
- Read data appears on `bus_rdata_o` in the cycle after the read and holds there until the next read.
- Registers sit at byte offsets 0x0 (restart command, reads as zero), 0x4 (configuration) and 0x8 (status).
- An access whose address bits 1:0 are not zero does nothing and reads as zero.

Top module: `wdog_window`

## Requirements
- R1: After reset, the configuration reads 0x3FFF2FFF, the counter holds 0xFFF, both status flags are clear and `fault_irq_o`, `cpu_rst_o` and `sys_rst_o` are low.
- R2: The first write to the configuration register after reset is stored and loads the counter with the new reload value. Every later write leaves the register unchanged until the next reset. The reload value is in bits 11:0 and the delta is in bits 27:16.
- R3: While counting is allowed, each `tick_i` pulse lowers the counter by one.
- R4: A write to offset 0x0 is a restart only when bits 31:24 equal 0xA5 and bit 0 is 1. Any other value written there changes nothing.
- R5: A restart while the counter is at or below the delta reloads the counter with the reload value. It sets no flag.
- R6: A restart while the counter is above the delta leaves the counter unchanged and sets the error flag, which is status bit 1.
- R7: A tick that finds the counter at zero sets the underflow flag, which is status bit 0. The same tick reloads the counter, and counting continues.
- R8: A status read returns the counter in bits 27:16 and the flags in bits 1:0, then clears the flags. A fault in the same cycle as the read is not returned by that read, but its flag stays set.
- R9: `fault_irq_o` is high while configuration bit 12 is set and either flag is set.
- R10: When configuration bit 13 is set, every fault pulses `cpu_rst_o` high for one cycle, in the cycle after the fault. `sys_rst_o` pulses with it unless configuration bit 14 (processor-only reset) is set.
- R11: With configuration bit 29 set, ticks are ignored while `idle_halt_i` is high. With bit 28 set, ticks are ignored while `dbg_halt_i` is high.
- R12: With configuration bit 15 set, ticks and restarts have no effect and no fault occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous system reset |
| tick_i | input | 1 | One-cycle 256 Hz count strobe |
| idle_halt_i | input | 1 | System idle indication |
| dbg_halt_i | input | 1 | Debugger halt indication |
| bus_en_i | input | 1 | Bus access strobe |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 4 | Byte offset of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, registered |
| fault_irq_o | output | 1 | Level fault interrupt |
| cpu_rst_o | output | 1 | Processor reset pulse |
| sys_rst_o | output | 1 | Full system reset pulse |

## Verification
The collision that matters is a status read in the same cycle as a new fault. Clear-on-read and flag setting then meet on the same edge.

The bench provokes this by running the counter down to zero and issuing the status read together with the final tick. It then judges three things:
- The read shows the flags as they were before the edge.
- The reset pulse still appears.
- A second read returns the underflow flag, which shows that setting the flag took priority over clearing it.

A behavioural model, compared every cycle, also covers restarts that meet a tick on the same edge.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  // register select, from byte offset bits 3:2
  typedef enum logic [1:0] {
    SEL_CMD  = 2'd0,
    SEL_CFG  = 2'd1,
    SEL_STAT = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  // configuration field positions
  localparam int RELOAD_LSB = 0;
  localparam int DELTA_LSB  = 16;
  localparam int IRQ_EN_BIT = 12;
  localparam int RST_EN_BIT = 13;
  localparam int PROC_BIT   = 14;
  localparam int OFF_BIT    = 15;
  localparam int DBG_BIT    = 28;
  localparam int IDLE_BIT   = 29;

  // status flag indices
  localparam int FLAG_UNF = 0;
  localparam int FLAG_ERR = 1;
  localparam int NFLAGS   = 2;

  typedef struct packed {
    logic irq_en;
    logic rst_en;
    logic proc_only;
    logic off;
    logic dbg_en;
    logic idle_en;
  } cfg_bits_t;
endpackage

// File: rtl/wdog_cfg_reg.sv
module wdog_cfg_reg #(
  parameter int          DW        = 32,
  parameter logic [31:0] RESET_VAL = 32'h3FFF2FFF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] cfg_q,
  output logic          first_wr
);
  logic locked;

  assign first_wr = wr_en && !locked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= RESET_VAL[DW-1:0];
      locked <= 1'b0;
    end else if (first_wr) begin
      cfg_q  <= wdata;
      locked <= 1'b1;
    end
  end

  AST_CFG_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> $stable(cfg_q)); // R2
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int               CW      = 12,
  parameter logic [CW-1:0]    RST_CNT = '1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          run,
  input  logic          off,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic [CW-1:0] reload,
  input  logic [CW-1:0] delta,
  input  logic          restart_req,
  output logic [CW-1:0] cnt_q,
  output logic          unf_evt,
  output logic          err_evt
);
  logic restart_live, in_window, restart_ok, step;

  assign restart_live = restart_req && !off;
  assign in_window    = (cnt_q <= delta);
  assign restart_ok   = restart_live && in_window;
  assign err_evt      = restart_live && !in_window;
  assign step         = tick && run && !off && !load && !restart_ok;
  assign unf_evt      = step && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt_q <= RST_CNT;
    else if (load)       cnt_q <= load_val;
    else if (restart_ok) cnt_q <= reload;
    else if (step)       cnt_q <= (cnt_q == '0) ? reload : cnt_q - 1'b1;
  end

  AST_RESTART_RELOADS: assert property (@(posedge clk) disable iff (!rst_n)
    (restart_req && !off && !load && cnt_q <= delta) |=> (cnt_q == $past(reload))); // R5
  AST_EARLY_NO_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (restart_req && !off && !load && !tick && cnt_q > delta) |=> $stable(cnt_q)); // R6
  AST_HALT_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !load && !(restart_req && !off)) |=> $stable(cnt_q)); // R11
  AST_OFF_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
    (off && !load) |=> $stable(cnt_q)); // R12
endmodule

// File: rtl/wdog_status.sv
module wdog_status
  import wdog_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              unf_evt,
  input  logic              err_evt,
  input  logic              clr,
  input  cfg_bits_t         cfg,
  output logic [NFLAGS-1:0] flags,
  output logic              irq_o,
  output logic              cpu_rst_o,
  output logic              sys_rst_o
);
  logic [NFLAGS-1:0] evt;
  logic              fault;

  assign evt[FLAG_UNF] = unf_evt;
  assign evt[FLAG_ERR] = err_evt;
  assign fault         = |evt;

  for (genvar i = 0; i < NFLAGS; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      flags[i] <= 1'b0;
      else if (evt[i]) flags[i] <= 1'b1;
      else if (clr)    flags[i] <= 1'b0;
    end
  end

  assign irq_o = cfg.irq_en && (|flags);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cpu_rst_o <= 1'b0;
      sys_rst_o <= 1'b0;
    end else begin
      cpu_rst_o <= fault && cfg.rst_en;
      sys_rst_o <= fault && cfg.rst_en && !cfg.proc_only;
    end
  end

  AST_UNF_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    unf_evt |=> flags[FLAG_UNF]); // R7
  AST_ERR_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    err_evt |=> flags[FLAG_ERR]); // R6
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !fault) |=> (flags == '0)); // R8
  AST_SYS_WITH_CPU: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_o |-> cpu_rst_o); // R10
  AST_RST_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (fault && !cfg.rst_en) |=> !cpu_rst_o); // R10
endmodule

// File: rtl/wdog_window.sv
module wdog_window
  import wdog_pkg::*;
#(
  parameter int          CW         = 12,
  parameter logic [7:0]  KEY_VAL    = 8'hA5,
  parameter logic [31:0] CFG_RESET  = 32'h3FFF2FFF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick_i,
  input  logic        idle_halt_i,
  input  logic        dbg_halt_i,
  input  logic        bus_en_i,
  input  logic        bus_we_i,
  input  logic [3:0]  bus_addr_i,
  input  logic [31:0] bus_wdata_i,
  output logic [31:0] bus_rdata_o,
  output logic        fault_irq_o,
  output logic        cpu_rst_o,
  output logic        sys_rst_o
);
  localparam int DW = 32;

  reg_sel_e          sel;
  logic              hit, wr_cmd, wr_cfg, rd_any, rd_stat, restart_req, run;
  logic              first_wr, unf_evt, err_evt;
  logic [DW-1:0]     cfg_q;
  logic [CW-1:0]     cnt_q;
  logic [NFLAGS-1:0] flags;
  cfg_bits_t         cfg;
  logic [DW-1:0]     rd_next;

  assign hit     = bus_en_i && (bus_addr_i[1:0] == 2'b00);
  assign sel     = reg_sel_e'(bus_addr_i[3:2]);
  assign wr_cmd  = hit && bus_we_i && (sel == SEL_CMD);
  assign wr_cfg  = hit && bus_we_i && (sel == SEL_CFG);
  assign rd_any  = bus_en_i && !bus_we_i;
  assign rd_stat = hit && !bus_we_i && (sel == SEL_STAT);
  assign restart_req = wr_cmd && (bus_wdata_i[31:24] == KEY_VAL) && bus_wdata_i[0];

  assign cfg.irq_en    = cfg_q[IRQ_EN_BIT];
  assign cfg.rst_en    = cfg_q[RST_EN_BIT];
  assign cfg.proc_only = cfg_q[PROC_BIT];
  assign cfg.off       = cfg_q[OFF_BIT];
  assign cfg.dbg_en    = cfg_q[DBG_BIT];
  assign cfg.idle_en   = cfg_q[IDLE_BIT];

  assign run = !(idle_halt_i && cfg.idle_en) && !(dbg_halt_i && cfg.dbg_en);

  wdog_cfg_reg #(.DW(DW), .RESET_VAL(CFG_RESET)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_cfg), .wdata(bus_wdata_i),
    .cfg_q(cfg_q), .first_wr(first_wr)
  );

  wdog_counter #(.CW(CW), .RST_CNT(CFG_RESET[RELOAD_LSB +: CW])) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick_i), .run(run), .off(cfg.off),
    .load(first_wr), .load_val(bus_wdata_i[RELOAD_LSB +: CW]),
    .reload(cfg_q[RELOAD_LSB +: CW]), .delta(cfg_q[DELTA_LSB +: CW]),
    .restart_req(restart_req), .cnt_q(cnt_q),
    .unf_evt(unf_evt), .err_evt(err_evt)
  );

  wdog_status u_stat (
    .clk(clk), .rst_n(rst_n), .unf_evt(unf_evt), .err_evt(err_evt),
    .clr(rd_stat), .cfg(cfg), .flags(flags),
    .irq_o(fault_irq_o), .cpu_rst_o(cpu_rst_o), .sys_rst_o(sys_rst_o)
  );

  always_comb begin
    rd_next = '0;
    if (hit) begin
      unique case (sel)
        SEL_CFG:  rd_next = cfg_q;
        SEL_STAT: begin
          rd_next[DELTA_LSB +: CW] = cnt_q;
          rd_next[NFLAGS-1:0]      = flags;
        end
        default:  rd_next = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bus_rdata_o <= '0;
    else if (rd_any) bus_rdata_o <= rd_next;
  end

  AST_BAD_CMD_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cmd && !restart_req && !tick_i) |=> $stable(cnt_q)); // R4
  AST_IRQ_FOLLOWS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_irq_o |-> (flags != '0))); // R9
endmodule

// File: tb/wdog_window_bench.sv
module wdog_window_bench;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n = 1'b0, tick = 1'b0, idle = 1'b0, dbg = 1'b0;
  logic en = 1'b0, we = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic irq, cpu_rst, sys_rst;
  int total = 0, bad = 0, cyc = 0;

  wdog_window u_wdog_window (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .idle_halt_i(idle),
    .dbg_halt_i(dbg), .bus_en_i(en), .bus_we_i(we), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .fault_irq_o(irq),
    .cpu_rst_o(cpu_rst), .sys_rst_o(sys_rst)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // behavioural reference model
  logic [31:0] m_cfg, m_rd;
  logic        m_lock, m_unf, m_err, m_irq, m_cpu, m_sys, m_live;
  int          m_cnt;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cfg = 32'h3FFF2FFF; m_lock = 0; m_cnt = 'hFFF; m_unf = 0; m_err = 0;
      m_rd = 0; m_irq = 0; m_cpu = 0; m_sys = 0; m_live = 0;
    end else begin : step
      logic ev_u, ev_e, moved, off, go;
      logic [31:0] old;
      int rl, dl;
      old = m_cfg; ev_u = 0; ev_e = 0; moved = 0;
      rl = int'(m_cfg[11:0]); dl = int'(m_cfg[27:16]); off = m_cfg[15];
      go = !off && !(idle && m_cfg[29]) && !(dbg && m_cfg[28]);
      if (en && !we) begin
        if (addr == 4'h4) m_rd = m_cfg;
        else if (addr == 4'h8) begin
          m_rd = {4'h0, m_cnt[11:0], 14'h0, m_err, m_unf};
          m_unf = 0; m_err = 0;
        end else m_rd = 0;
      end
      if (en && we && addr == 4'h4 && !m_lock) begin
        m_cfg = wdata; m_lock = 1; m_cnt = int'(wdata[11:0]); moved = 1;
      end else if (en && we && addr == 4'h0 && wdata[31:24] == 8'hA5 && wdata[0] && !off) begin
        if (m_cnt <= dl) begin m_cnt = rl; moved = 1; end
        else ev_e = 1;
      end
      if (!moved && tick && go) begin
        if (m_cnt == 0) begin ev_u = 1; m_cnt = rl; end
        else m_cnt = m_cnt - 1;
      end
      if (ev_u) m_unf = 1;
      if (ev_e) m_err = 1;
      m_cpu = (ev_u || ev_e) && old[13];
      m_sys = m_cpu && !old[14];
      m_irq = m_cfg[12] && (m_unf || m_err);
      m_live = 1;
    end
  end

  always @(negedge clk) begin
    if (rst_n && m_live) begin
      check("R8 model rdata", rdata, m_rd);
      check("R9 model irq", {31'b0, irq}, {31'b0, m_irq});
      check("R10 model cpu_rst", {31'b0, cpu_rst}, {31'b0, m_cpu});
      check("R10 model sys_rst", {31'b0, sys_rst}, {31'b0, m_sys});
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      bad++; total++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic do_reset();
    rst_n = 0; en = 0; tick = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask
  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    en = 1; we = 1; addr = a; wdata = d;
    @(negedge clk);
    en = 0; we = 0;
  endtask
  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    en = 1; we = 0; addr = a;
    @(negedge clk);
    en = 0; d = rdata;
  endtask
  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick = 1; @(negedge clk); tick = 0; @(negedge clk);
    end
  endtask

  logic [31:0] v;
  initial begin
    do_reset();
    check("R1 outputs", {29'b0, irq, cpu_rst, sys_rst}, 32'h0);
    rd(4'h4, v); check("R1 cfg reset", v, 32'h3FFF2FFF);
    rd(4'h8, v); check("R1 status reset", v, 32'h0FFF0000);
    ticks(3);
    rd(4'h8, v); check("R3 count down", v, 32'h0FFC0000);
    wr(4'h0, 32'hA500_0001);
    rd(4'h8, v); check("R5 restart in window", v, 32'h0FFF0000);
    ticks(2);
    wr(4'h0, 32'h5A00_0001);
    rd(4'h8, v); check("R4 wrong key", v, 32'h0FFD0000);
    wr(4'h0, 32'hA500_0000);
    rd(4'h8, v); check("R4 bit0 clear", v, 32'h0FFD0000);
    wr(4'h4, 32'h3005_3014);
    rd(4'h4, v); check("R2 first cfg write", v, 32'h3005_3014);
    rd(4'h8, v); check("R2 counter loaded", v, 32'h0014_0000);
    wr(4'h4, 32'h0000_8001);
    rd(4'h4, v); check("R2 second write ignored", v, 32'h3005_3014);
    wr(4'h0, 32'hA500_0001);
    check("R10 early cpu_rst", {31'b0, cpu_rst}, 32'h1);
    check("R10 early sys_rst", {31'b0, sys_rst}, 32'h1);
    check("R9 irq raised", {31'b0, irq}, 32'h1);
    rd(4'h8, v); check("R6 early restart", v, 32'h0014_0002);
    check("R9 irq after clear", {31'b0, irq}, 32'h0);
    rd(4'h8, v); check("R8 cleared on read", v, 32'h0014_0000);
    idle = 1; ticks(3); idle = 0;
    rd(4'h8, v); check("R11 idle freeze", v, 32'h0014_0000);
    dbg = 1; ticks(3); dbg = 0;
    rd(4'h8, v); check("R11 debug freeze", v, 32'h0014_0000);
    ticks(16);
    wr(4'h0, 32'hA500_0001);
    rd(4'h8, v); check("R5 late restart", v, 32'h0014_0000);
    ticks(20);
    rd(4'h8, v); check("R3 at zero", v, 32'h0000_0000);
    tick = 1;
    rd(4'h8, v); tick = 0;
    check("R8 read with fault", v, 32'h0000_0000);
    check("R10 underflow cpu_rst", {31'b0, cpu_rst}, 32'h1);
    rd(4'h8, v); check("R7 underflow kept", v, 32'h0014_0001);
    // disabled configuration
    do_reset();
    wr(4'h4, 32'h0000_E00A);
    ticks(3);
    rd(4'h8, v); check("R12 no count", v, 32'h000A_0000);
    wr(4'h0, 32'hA500_0001);
    check("R12 no reset pulse", {31'b0, cpu_rst}, 32'h0);
    rd(4'h8, v); check("R12 no fault", v, 32'h000A_0000);
    // processor-only reset
    do_reset();
    wr(4'h4, 32'h0002_600A);
    wr(4'h0, 32'hA500_0001);
    check("R10 proc cpu_rst", {31'b0, cpu_rst}, 32'h1);
    check("R10 proc sys_rst", {31'b0, sys_rst}, 32'h0);
    check("R9 irq disabled", {31'b0, irq}, 32'h0);
    rd(4'h8, v); check("R6 err flag", v, 32'h000A_0002);
    @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule